// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block is the master side of a stereo serial audio link. It takes a left and right sample pair over a valid/ready handshake and produces three lines: a bit clock, a left/right frame clock and a serial data line. Data is sent MSB first.

A 2-bit format input selects one of four framings. The choices are right-justified, left-justified, I2S, and a DSP framing in which one frame-sync pulse leads back-to-back left and right words. A polarity input works in two ways. In the three non-DSP framings it inverts the frame clock. In DSP framing it selects early or late data start.

Format and polarity are sampled only at frame boundaries, so a frame is never emitted with mixed settings. The bit clock is the system clock divided by two. Each frame holds `2*SLOT_W` bit periods, and each half-frame carries one `DATA_W`-bit word.

Top module: `audio_ser_tx`

## Requirements
- R1: `bclk_o` is low for the first clock and high for the second clock of every bit slot, so it toggles on every clock. A frame is `2*SLOT_W` bit slots, and `lrclk_o` and `sdata_o` change only when `bclk_o` falls.
- R2: Format code 2'b10 (I2S) and polarity 0 are the reset defaults. During reset `bclk_o`, `lrclk_o` and `sdata_o` are 0 and `ready_o` is 1. The first frame after reset uses the defaults and carries zero samples.
- R3: Format code 2'b01 (left-justified): the left word starts with its MSB in slot 0 of the first half-frame, and the right word does the same in the second half. `lrclk_o` is high for the left half when polarity is 0.
- R4: Format code 2'b00 (right-justified): each word ends with its LSB in the last slot of its half-frame. `lrclk_o` is high for the left half when polarity is 0.
- R5: Format code 2'b10 (I2S): each word's MSB comes one slot after the frame clock edge. `lrclk_o` is low for the left half when polarity is 0.
- R6: In the three non-DSP formats, polarity 1 inverts `lrclk_o` and leaves the data slots unchanged.
- R7: Format code 2'b11 (DSP): `lrclk_o` is high only in slot 0 of the frame. With polarity 0 (early), the left MSB is in slot 1 and the right word follows the left LSB directly.
- R8: DSP format with polarity 1 (late): the left MSB is in slot 0, the same slot as the sync pulse, and the right word follows directly.
- R9: Changes of `fmt_i` or `pol_i` inside a frame have no effect. The values present on the last clock of a frame apply to the whole next frame.
- R10: `ready_o` is high exactly when no sample pair is pending. An accepted pair is sent in the next frame. A frame that starts with no pair pending sends zero words.
- R11: `sdata_o` is 0 in every slot that carries no data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (twice the bit rate) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fmt_i | input | 2 | Framing: 00 right-justified, 01 left-justified, 10 I2S, 11 DSP |
| pol_i | input | 1 | Frame clock invert (non-DSP) or late start (DSP) |
| valid_i | input | 1 | Sample pair valid |
| left_i | input | DATA_W | Left sample |
| right_i | input | DATA_W | Right sample |
| ready_o | output | 1 | Pending slot empty |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame clock / frame sync |
| sdata_o | output | 1 | Serial data |

## Verification
The bench builds the block with `DATA_W=8` and `SLOT_W=10`, which gives a 20-slot, 40-clock frame. At that size it can compare every output on every clock across two passes of all eight format/polarity combinations. It also brings the slot edges into reach: I2S ending one slot before the half boundary, right-justified starting two slots in, and DSP words ending inside the frame. The bench also drives wrong format values partway through each frame, and it skips one push to produce an underrun frame.

// File: rtl/ast_pkg.sv
package ast_pkg;
  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_I2S = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;
endpackage

// File: rtl/ast_timing.sv
module ast_timing #(
  parameter int SLOT_W = 32,
  localparam int CW = $clog2(2 * SLOT_W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          phase_o,
  output logic [CW-1:0] slot_o,
  output logic          wrap_o
);
  localparam logic [CW-1:0] LAST = CW'(2 * SLOT_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= 1'b0;
      slot_o  <= '0;
    end else begin
      phase_o <= ~phase_o;
      if (phase_o) slot_o <= (slot_o == LAST) ? '0 : slot_o + 1'b1;
    end
  end

  assign wrap_o = phase_o && (slot_o == LAST);

  a_r1_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (slot_o == '0) && !phase_o);
  a_r1_slot_holds_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_o |=> $stable(slot_o));
endmodule

// File: rtl/ast_framer.sv
module ast_framer
  import ast_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int SLOT_W = 32,
  localparam int CW = $clog2(2 * SLOT_W)
) (
  input  fmt_e              fmt_i,
  input  logic              pol_i,
  input  logic [CW-1:0]     slot_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  output logic              lr_o,
  output logic              sd_o
);
  int b, p, t, amt;
  logic half;
  logic [DATA_W-1:0] word, shifted;

  always_comb begin
    b    = int'(slot_i);
    half = (b >= SLOT_W);
    p    = half ? b - SLOT_W : b;
    word = half ? right_i : left_i;
    amt  = -1;
    t    = 0;
    lr_o = 1'b0;
    unique case (fmt_i)
      FMT_RJ: begin
        lr_o = ~half ^ pol_i;
        if (p >= SLOT_W - DATA_W) amt = SLOT_W - 1 - p;
      end
      FMT_LJ: begin
        lr_o = ~half ^ pol_i;
        if (p < DATA_W) amt = DATA_W - 1 - p;
      end
      FMT_I2S: begin
        lr_o = half ^ pol_i;
        if (p >= 1 && p <= DATA_W) amt = DATA_W - p;
      end
      FMT_DSP: begin
        lr_o = (b == 0);
        t    = pol_i ? b : b - 1;  // late starts on the pulse
        if (t >= 0 && t < DATA_W) begin
          word = left_i;
          amt  = DATA_W - 1 - t;
        end else if (t >= DATA_W && t < 2 * DATA_W) begin
          word = right_i;
          amt  = 2 * DATA_W - 1 - t;
        end
      end
      default: ;
    endcase
    shifted = word >> ((amt < 0) ? 0 : amt);
    sd_o    = (amt >= 0) && shifted[0];
  end
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
  import ast_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int SLOT_W = 32  // needs 2*SLOT_W > 2*DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        fmt_i,
  input  logic              pol_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  output logic              ready_o,
  output logic              bclk_o,
  output logic              lrclk_o,
  output logic              sdata_o
);
  localparam int CW = $clog2(2 * SLOT_W);

  logic          phase, wrap;
  logic [CW-1:0] slot;
  fmt_e          act_fmt;
  logic          act_pol;
  logic          pend_v;
  logic [DATA_W-1:0] pend_l, pend_r, cur_l, cur_r;
  logic          lr, sd;

  ast_timing #(.SLOT_W(SLOT_W)) u_timing (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_o(phase),
    .slot_o (slot),
    .wrap_o (wrap)
  );

  assign ready_o = ~pend_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_fmt <= FMT_I2S;
      act_pol <= 1'b0;
      pend_v  <= 1'b0;
      pend_l  <= '0;
      pend_r  <= '0;
      cur_l   <= '0;
      cur_r   <= '0;
    end else begin
      if (wrap) begin
        act_fmt <= fmt_e'(fmt_i);
        act_pol <= pol_i;
        cur_l   <= pend_v ? pend_l : '0;
        cur_r   <= pend_v ? pend_r : '0;
      end
      if (valid_i && ready_o) begin
        pend_v <= 1'b1;
        pend_l <= left_i;
        pend_r <= right_i;
      end else if (wrap) begin
        pend_v <= 1'b0;
      end
    end
  end

  ast_framer #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_framer (
    .fmt_i  (act_fmt),
    .pol_i  (act_pol),
    .slot_i (slot),
    .left_i (cur_l),
    .right_i(cur_r),
    .lr_o   (lr),
    .sd_o   (sd)
  );

  assign bclk_o  = phase;
  assign lrclk_o = lr;
  assign sdata_o = sd;

  a_r1_bclk_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (bclk_o != $past(bclk_o)));
  a_r1_lines_move_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bclk_o |=> $stable(lrclk_o) && $stable(sdata_o));
  a_r9_cfg_frame_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(act_fmt) && $stable(act_pol));
  a_r10_accept_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o);
  a_r7_sync_single_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_fmt == FMT_DSP && slot != '0) |-> !lrclk_o);
endmodule

// File: tb/sim_audio_ser_tx.sv
`timescale 1ns/1ps
module sim_audio_ser_tx;
  localparam int D = 8;
  localparam int S = 10;
  localparam int FR = 4 * S;  // clocks per frame
  localparam int NF = 19;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] fmt = 2'b00;
  logic pol = 1'b0, valid = 1'b0;
  logic [D-1:0] left = '0, right = '0;
  logic ready, bclk, lrclk, sdata;
  int n_run = 0, n_fail = 0;
  int ef[32], ep[32], el[32], er[32];

  always #4 clk = ~clk;

  audio_ser_tx #(.DATA_W(D), .SLOT_W(S)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .pol_i(pol), .valid_i(valid),
    .left_i(left), .right_i(right), .ready_o(ready), .bclk_o(bclk),
    .lrclk_o(lrclk), .sdata_o(sdata)
  );

  task automatic chk(string req, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // returns {lr, sd}
  function automatic logic [1:0] model(int b, int f, int pl, int l, int r);
    int h, p, w, idx, t;
    logic lrv;
    h = b / S; p = b % S; w = (h != 0) ? r : l; idx = -1; lrv = 1'b0;
    case (f)
      0: begin lrv = logic'((1 - h) ^ pl); if (p >= S - D) idx = S - 1 - p; end
      1: begin lrv = logic'((1 - h) ^ pl); if (p < D) idx = D - 1 - p; end
      2: begin lrv = logic'(h ^ pl); if (p >= 1 && p <= D) idx = D - p; end
      default: begin
        lrv = (b == 0);
        t = b - ((pl != 0) ? 0 : 1);
        if (t >= 0 && t < D) begin w = l; idx = D - 1 - t; end
        else if (t >= D && t < 2 * D) begin w = r; idx = 2 * D - 1 - t; end
      end
    endcase
    return {lrv, (idx >= 0) ? logic'((w >> idx) & 1) : 1'b0};
  endfunction

  function automatic string tag(int f, int pl, int fr);
    string s;
    case (f)
      0: s = "R4"; 1: s = "R3"; 2: s = "R5"; default: s = (pl != 0) ? "R8" : "R7";
    endcase
    if (f != 3 && pl != 0) s = {s, "/R6"};
    if (fr == 0) s = {s, "/R2"};
    if (fr == 17) s = {s, "/R10"};
    if (fr >= 1) s = {s, "/R9"};
    return {s, "/R11"};
  endfunction

  task automatic run();
    logic [1:0] e;
    ef[0] = 2; ep[0] = 0; el[0] = 0; er[0] = 0;
    #20;
    chk("R2 bclk reset", bclk, 1'b0);
    chk("R2 lrclk reset", lrclk, 1'b0);
    chk("R2 sdata reset", sdata, 1'b0);
    chk("R2 ready reset", ready, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < NF * FR; k++) begin
      int f, r, b, c;
      #1;
      f = k / FR; r = k % FR; b = (k / 2) % (2 * S);
      chk("R1 bclk", bclk, logic'(k % 2));
      e = model(b, ef[f], ep[f], el[f], er[f]);
      chk({tag(ef[f], ep[f], f), " lrclk"}, lrclk, e[1]);
      chk({tag(ef[f], ep[f], f), " sdata"}, sdata, e[0]);
      if (r == 0 && f >= 1) chk("R10 ready after boundary", ready, 1'b1);
      c = f % 16;
      if (r == 2) begin
        ef[f+1] = (c / 2) % 4; ep[f+1] = c % 2;
        // R9: wrong values first, corrected before frame end
        fmt = 2'((ef[f+1] + 1) % 4); pol = ~logic'(ep[f+1]);
        if (f != 16) begin
          el[f+1] = (f * 37 + 5) % 256; er[f+1] = (f * 91 + 200) % 256;
          left = D'(el[f+1]); right = D'(er[f+1]); valid = 1'b1;
        end else begin
          el[f+1] = 0; er[f+1] = 0;
        end
      end
      if (r == 3) begin
        if (f != 16) chk("R10 ready drops", ready, 1'b0);
        else chk("R10 ready idle", ready, 1'b1);
        valid = 1'b0;
      end
      if (r == FR - 6) begin
        fmt = 2'(ef[f+1]); pol = logic'(ep[f+1]);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    fork
      run();
      begin
        #(200000 * 8);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule